// File: doc/BRIEF.md
# Folded Bitwise Likelihood Generator

This block repairs a B-bit result word that reaches it as N separate observations, each of which may carry an additive hardware error. It does not vote. It uses stored error statistics and searches every possible error-free value for the one that best explains the observations. The search is folded in time. One candidate value is scored per clock, so a full sweep takes 2^B cycles. For each candidate the score is a cost: the stored prior cost of the candidate plus, for each observation, the stored error cost of the difference between that observation and the candidate.

All costs are 8-bit non-negative numbers. Each one stands for a rounded negative base-2 logarithm of a probability, and 255 stands for an impossible event. Smaller totals are therefore more likely. For every output bit, two compare-select registers keep the lowest total seen so far: one over the candidates whose bit is 0, the other over those whose bit is 1. When the sweep ends, each bit gets a signed log-likelihood ratio, which is the bit-0 minimum minus the bit-1 minimum. A slicer turns that ratio into the corrected hard bit.

The cost tables are written through a simple write port while the block is idle. A run begins with a start pulse and ends with a one-cycle done pulse. The results are then held until the next run finishes.

Top module: `lg_folded_llr`

## Requirements
- R1: After reset, busy and done are low, every LLR field is zero, hard is zero, and every table entry costs 0.
- R2: A start seen while idle latches the observations. Busy is high from the next cycle until done. Done is a single-cycle pulse that appears 2^B+1 clock edges after the start edge, and busy is low while done is high.
- R3: The cost of candidate c is prior[c] + sum over j of err_j[(obs_j − c) mod 2^B]. Each observation j has its own error table. Observation j occupies obs_flat[j*B +: B].
- R4: For output bit i, the LLR is (minimum cost over candidates with bit i = 0) − (minimum cost over candidates with bit i = 1). It is a two's-complement value of width LW in llr_flat[i*LW +: LW].
- R5: Hard bit i is 1 only when LLR i is strictly positive. A zero LLR gives 0.
- R6: The cost sum never wraps. With every entry at 255, the total of (N+1)*255 is exact.
- R7: Table writes use wr_sel 0 for the prior table and wr_sel j+1 for the error table of observation j, with wr_addr as the index. A write issued while busy has no effect.
- R8: A start issued while busy is ignored. It neither restarts nor lengthens the sweep, and it produces no extra done.
- R9: LLR and hard change only at the done pulse. A change to the observation inputs after the start edge does not affect the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | SEL_W | Table select: 0 prior, j+1 error table j |
| wr_addr | input | B | Entry index within the selected table |
| wr_data | input | 8 | Cost value to store |
| start | input | 1 | Begin a sweep (taken only while idle) |
| obs_flat | input | N*B | Packed observations, observation j at [j*B +: B] |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle result strobe |
| llr_flat | output | B*LW | Packed signed per-bit LLRs |
| hard | output | B | Corrected word |

## Verification
A wrong compare-select register, a wrong error index or a wrong accumulator width cannot stay hidden. It changes at least one signed LLR field at the next done pulse, which comes 2^B+1 cycles after start, and it often flips the hard word as well. Tie cases, wrap-around error indices and all-255 tables are chosen so that each of these faults gives its own value at the ports. A stray control state shows up as a done pulse that is early, late, missing or doubled, or as busy falling at the wrong edge. The effect is seen within a single sweep. A table write that slips through while the block is busy is seen in the next run's results.

// File: rtl/lg_pkg.sv
package lg_pkg;
    localparam int COST_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_FINISH = 2'd2
    } lg_state_e;
endpackage

// File: rtl/lg_cost_store.sv
module lg_cost_store #(
    parameter int B     = 3,
    parameter int N     = 3,
    parameter int SEL_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         locked,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [B-1:0]                 wr_addr,
    input  logic [lg_pkg::COST_W-1:0]    wr_data,
    input  logic [B-1:0]                 rd_cand,
    input  logic [N*B-1:0]               rd_err_idx,
    output logic [lg_pkg::COST_W-1:0]    prior_cost,
    output logic [N*lg_pkg::COST_W-1:0]  err_cost_flat
);
    localparam int CW    = lg_pkg::COST_W;
    localparam int DEPTH = 1 << B;

    logic [CW-1:0] prior_d [DEPTH];
    logic [CW-1:0] prior_q [DEPTH];
    logic [CW-1:0] err_d   [N][DEPTH];
    logic [CW-1:0] err_q   [N][DEPTH];

    always_comb begin
        prior_d = prior_q;
        err_d   = err_q;
        if (wr_en && !locked) begin
            if (wr_sel == '0) begin
                prior_d[wr_addr] = wr_data;
            end
            for (int j = 0; j < N; j++) begin
                if (wr_sel == SEL_W'(j + 1)) begin
                    err_d[j][wr_addr] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                prior_q[a] <= '0;
                for (int j = 0; j < N; j++) begin
                    err_q[j][a] <= '0;
                end
            end
        end else begin
            prior_q <= prior_d;
            err_q   <= err_d;
        end
    end

    assign prior_cost = prior_q[rd_cand];

    for (genvar j = 0; j < N; j++) begin : g_err_rd
        assign err_cost_flat[j*CW +: CW] = err_q[j][rd_err_idx[j*B +: B]];
    end

    // R7: a write attempted during a sweep leaves the prior entry untouched
    a_r7_prior_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en) |=> (prior_q[$past(wr_addr)] == $past(prior_q[wr_addr])));
endmodule

// File: rtl/lg_word_metric.sv
module lg_word_metric #(
    parameter int B  = 3,
    parameter int N  = 3,
    parameter int MW = 10
) (
    input  logic [B-1:0]                 cand,
    input  logic [N*B-1:0]               obs_flat,
    input  logic [lg_pkg::COST_W-1:0]    prior_cost,
    input  logic [N*lg_pkg::COST_W-1:0]  err_cost_flat,
    output logic [N*B-1:0]               err_idx_flat,
    output logic [MW-1:0]                metric
);
    localparam int CW = lg_pkg::COST_W;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            err_idx_flat[j*B +: B] = obs_flat[j*B +: B] - cand;
        end
        metric = MW'(prior_cost);
        for (int j = 0; j < N; j++) begin
            metric = metric + MW'(err_cost_flat[j*CW +: CW]);
        end
    end
endmodule

// File: rtl/lg_cs_bank.sv
module lg_cs_bank #(
    parameter int B  = 3,
    parameter int MW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            upd,
    input  logic [B-1:0]    cand,
    input  logic [MW-1:0]   metric,
    output logic [B*MW-1:0] min0_flat,
    output logic [B*MW-1:0] min1_flat
);
    logic [MW-1:0] min0_d [B];
    logic [MW-1:0] min0_q [B];
    logic [MW-1:0] min1_d [B];
    logic [MW-1:0] min1_q [B];

    always_comb begin
        min0_d = min0_q;
        min1_d = min1_q;
        for (int i = 0; i < B; i++) begin
            if (init) begin
                min0_d[i] = '1;
                min1_d[i] = '1;
            end else if (upd) begin
                if (cand[i]) begin
                    if (metric < min1_q[i]) min1_d[i] = metric;
                end else begin
                    if (metric < min0_q[i]) min0_d[i] = metric;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < B; i++) begin
                min0_q[i] <= '1;
                min1_q[i] <= '1;
            end
        end else begin
            min0_q <= min0_d;
            min1_q <= min1_d;
        end
    end

    for (genvar i = 0; i < B; i++) begin : g_cs
        assign min0_flat[i*MW +: MW] = min0_q[i];
        assign min1_flat[i*MW +: MW] = min1_q[i];

        // R4: running minima never grow during a sweep
        a_r4_min_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            upd |=> ((min0_q[i] <= $past(min0_q[i])) && (min1_q[i] <= $past(min1_q[i]))));
    end
endmodule

// File: rtl/lg_folded_llr.sv
module lg_folded_llr #(
    parameter int B     = 3,
    parameter int N     = 3,
    parameter int MW    = $clog2((N + 1) * ((1 << lg_pkg::COST_W) - 1) + 1),
    parameter int LW    = MW + 1,
    parameter int SEL_W = $clog2(N + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [B-1:0]              wr_addr,
    input  logic [lg_pkg::COST_W-1:0] wr_data,
    input  logic                      start,
    input  logic [N*B-1:0]            obs_flat,
    output logic                      busy,
    output logic                      done,
    output logic [B*LW-1:0]           llr_flat,
    output logic [B-1:0]              hard
);
    import lg_pkg::*;
    localparam int CW = COST_W;

    typedef struct packed {
        lg_state_e        st;
        logic [B-1:0]     cand;
        logic [N*B-1:0]   obs;
        logic             done;
        logic [B*LW-1:0]  llr;
        logic [B-1:0]     hard;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic                cs_init, cs_upd;
    logic [CW-1:0]       prior_cost;
    logic [N*CW-1:0]     err_cost_flat;
    logic [N*B-1:0]      err_idx_flat;
    logic [MW-1:0]       metric;
    logic [B*MW-1:0]     min0_flat, min1_flat;
    logic signed [LW-1:0] diff_v;

    assign busy = (ctrl_q.st != ST_IDLE);

    lg_cost_store #(.B(B), .N(N), .SEL_W(SEL_W)) i_store (
        .clk(clk), .rst_n(rst_n), .locked(busy),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_cand(ctrl_q.cand), .rd_err_idx(err_idx_flat),
        .prior_cost(prior_cost), .err_cost_flat(err_cost_flat)
    );

    lg_word_metric #(.B(B), .N(N), .MW(MW)) i_metric (
        .cand(ctrl_q.cand), .obs_flat(ctrl_q.obs),
        .prior_cost(prior_cost), .err_cost_flat(err_cost_flat),
        .err_idx_flat(err_idx_flat), .metric(metric)
    );

    lg_cs_bank #(.B(B), .MW(MW)) i_cs (
        .clk(clk), .rst_n(rst_n), .init(cs_init), .upd(cs_upd),
        .cand(ctrl_q.cand), .metric(metric),
        .min0_flat(min0_flat), .min1_flat(min1_flat)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        cs_init     = 1'b0;
        cs_upd      = 1'b0;
        diff_v      = '0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.st   = ST_SWEEP;
                    ctrl_d.cand = '0;
                    ctrl_d.obs  = obs_flat;
                    cs_init     = 1'b1;
                end
            end
            ST_SWEEP: begin
                cs_upd = 1'b1;
                if (ctrl_q.cand == {B{1'b1}}) begin
                    ctrl_d.st = ST_FINISH;
                end else begin
                    ctrl_d.cand = ctrl_q.cand + B'(1);
                end
            end
            ST_FINISH: begin
                for (int i = 0; i < B; i++) begin
                    diff_v = LW'(min0_flat[i*MW +: MW]) - LW'(min1_flat[i*MW +: MW]);
                    ctrl_d.llr[i*LW +: LW] = diff_v;
                    ctrl_d.hard[i]         = (diff_v > 0);
                end
                ctrl_d.done = 1'b1;
                ctrl_d.st   = ST_IDLE;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, cand: '0, obs: '0, done: 1'b0, llr: '0, hard: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign done     = ctrl_q.done;
    assign llr_flat = ctrl_q.llr;
    assign hard     = ctrl_q.hard;

    // R2: an idle start raises busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2: done lasts one cycle and never overlaps busy
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: a start during the sweep does not end or restart it
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_q.st == ST_SWEEP && start) |=> busy);
    // R9: results move only together with done
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(llr_flat) && $stable(hard)));
endmodule

// File: tb/test_lg_folded_llr.sv
module test_lg_folded_llr;
    localparam int CLK_PERIOD = 10;
    localparam int B  = 3;
    localparam int N  = 3;
    localparam int NC = 1 << B;
    localparam int MW = $clog2((N + 1) * 255 + 1);
    localparam int LW = MW + 1;
    localparam int SW = $clog2(N + 1);

    // obs0, obs1, obs2, expected hard, expected llr bit0..bit2 (error cost 0 on match, 10 otherwise)
    localparam int VEC [5][7] = '{
        '{5, 5, 5, 5,  30, -30,  30},
        '{2, 2, 7, 2, -10,  20, -10},
        '{1, 4, 6, 0,   0,   0,   0},
        '{0, 0, 0, 0, -30, -30, -30},
        '{7, 7, 7, 7,  30,  30,  30}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, start = 1'b0;
    logic [SW-1:0] wr_sel = '0;
    logic [B-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [N*B-1:0] obs_flat = '0;
    logic busy, done;
    logic [B*LW-1:0] llr_flat;
    logic [B-1:0] hard;

    int prior_m [NC];
    int err_m [N][NC];
    int exp_llr [B];
    int exp_hard;
    int n_tests = 0, n_fail = 0;
    int done_cycle;
    bit finished = 0;

    lg_folded_llr #(.B(B), .N(N)) i_lg_folded_llr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .obs_flat(obs_flat), .busy(busy),
        .done(done), .llr_flat(llr_flat), .hard(hard)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int llr_of(input int i);
        logic signed [LW-1:0] v;
        v = llr_flat[i*LW +: LW];
        return int'(v);
    endfunction

    task automatic model(input int o0, input int o1, input int o2);
        int m0 [B];
        int m1 [B];
        int ob [N];
        ob[0] = o0; ob[1] = o1; ob[2] = o2;
        for (int i = 0; i < B; i++) begin m0[i] = 1 << 20; m1[i] = 1 << 20; end
        for (int c = 0; c < NC; c++) begin
            int m = prior_m[c];
            for (int j = 0; j < N; j++) m += err_m[j][(ob[j] - c) & (NC - 1)];
            for (int i = 0; i < B; i++) begin
                if ((c >> i) & 1) begin if (m < m1[i]) m1[i] = m; end
                else begin if (m < m0[i]) m0[i] = m; end
            end
        end
        exp_hard = 0;
        for (int i = 0; i < B; i++) begin
            exp_llr[i] = m0[i] - m1[i];
            if (exp_llr[i] > 0) exp_hard |= (1 << i);
        end
    endtask

    task automatic wr(input int sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SW'(sel); wr_addr = B'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 0) prior_m[addr] = data; else err_m[sel-1][addr] = data;
    endtask

    task automatic fill(input int prior_v, input int match_v, input int miss_v);
        for (int a = 0; a < NC; a++) begin
            wr(0, a, prior_v);
            for (int j = 0; j < N; j++) wr(j + 1, a, (a == 0) ? match_v : miss_v);
        end
    endtask

    // mid: 0 none, 1 extra start at cycle 3, 2 prior write at cycle 2, 3 change obs at cycle 2
    task automatic run(input int o0, input int o1, input int o2, input int mid, input string tag);
        @(negedge clk);
        obs_flat = {B'(o2), B'(o1), B'(o0)};
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        done_cycle = -1;
        for (int k = 1; k <= 3 * NC; k++) begin
            if (k == 2 && mid == 2) begin
                wr_en = 1'b1; wr_sel = '0; wr_addr = B'(2); wr_data = 8'd0;
            end
            if (k == 2 && mid == 3) obs_flat = {B'(7 - o2), B'(7 - o1), B'(7 - o0)};
            if (k == 3 && mid == 1) start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
            if (done) begin
                if (done_cycle < 0) done_cycle = k;
                else check(0, {tag, " R8 second done"}, k, -1);
            end else if (done_cycle < 0 && k <= NC) begin
                check(busy, {tag, " R2 busy during sweep"}, busy, 1);
            end
            if (done_cycle > 0 && k == done_cycle) begin
                check(!busy, {tag, " R2 busy low at done"}, busy, 0);
                model(o0, o1, o2);
                for (int i = 0; i < B; i++)
                    check(llr_of(i) == exp_llr[i], {tag, " R4 llr vs model"}, llr_of(i), exp_llr[i]);
                check(int'(hard) == exp_hard, {tag, " R5 hard vs model"}, hard, exp_hard);
            end
        end
        check(done_cycle == NC + 1, {tag, " R2 done latency"}, done_cycle, NC + 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R2 actual=hang expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NC; a++) begin
            prior_m[a] = 0;
            for (int j = 0; j < N; j++) err_m[j][a] = 0;
        end
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1 control idle", {busy, done}, 0);
        check(llr_flat == '0, "R1 llr zero", 1, 0);
        check(hard == '0, "R1 hard zero", hard, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: tables start at zero, so every LLR is a tie
        run(3, 5, 6, 0, "R1 zero tables");
        check(llr_of(0) == 0 && hard == '0, "R1 zero table result", llr_of(0), 0);

        // Vector walk: R3 R4 R5 under uniform match/miss costs
        fill(0, 0, 10);
        for (int v = 0; v < 5; v++) begin
            run(VEC[v][0], VEC[v][1], VEC[v][2], 0, "R3 vector");
            check(int'(hard) == VEC[v][3], "R5 vector hard", hard, VEC[v][3]);
            for (int i = 0; i < B; i++)
                check(llr_of(i) == VEC[v][4+i], "R4 vector llr", llr_of(i), VEC[v][4+i]);
        end

        // R3: error index wraps; small negative errors are likely, result beats majority
        for (int j = 0; j < N; j++)
            for (int a = 0; a < NC; a++)
                wr(j + 1, a, (a == 0) ? 0 : (a == 7) ? 2 : (a == 1) ? 6 : 20);
        run(0, 0, 1, 0, "R3 wrap");
        check(hard == 3'd1, "R3 wrap non-majority", hard, 1);

        // R3: per-observation tables are distinct
        wr(3, 1, 0);
        run(0, 0, 1, 0, "R3 per-obs table");

        // R3: the prior alone decides when error costs are flat
        fill(20, 0, 0);
        wr(0, 3, 0);
        run(6, 1, 4, 0, "R3 prior");
        check(hard == 3'd3, "R3 prior picks 3", hard, 3);

        // R6: saturated tables, candidate 5 cheapest at 765 vs 1020
        fill(255, 255, 255);
        wr(0, 5, 0);
        run(2, 4, 6, 0, "R6 saturate");
        check(hard == 3'd5, "R6 hard", hard, 5);
        check(llr_of(0) == 255 && llr_of(1) == -255, "R6 llr no wrap", llr_of(1), -255);

        // R7: write during busy ignored (shadow unchanged, model would differ if accepted)
        run(2, 4, 6, 2, "R7 locked write");
        run(2, 4, 6, 0, "R7 after locked write");
        check(hard == 3'd5, "R7 prior[2] still 255", hard, 5);

        // R8: start during busy ignored
        run(2, 4, 6, 1, "R8 extra start");

        // R9: obs change mid-sweep does not matter; outputs held after done
        fill(0, 0, 10);
        run(5, 5, 5, 3, "R9 obs latched");
        check(hard == 3'd5, "R9 latched hard", hard, 5);
        obs_flat = '0;
        repeat (6) @(negedge clk);
        check(hard == 3'd5 && llr_of(1) == -30, "R9 held", llr_of(1), -30);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule